// File: doc/BRIEF.md
# Expanded Memory Page Mapper

This block lets a small real-mode system see more RAM than its address space allows. It opens a 64 KB window in the upper memory area, split into four 16 KB pages. Each page has a byte-wide page register in I/O space. When a page is enabled, any CPU access inside that page is steered to a selectable 16 KB slot of physical RAM. When a page is disabled, its range is left to the external bus.

A control byte sets two things. Its low nibble picks the position of the window in memory. Its high nibble picks the I/O location of the page registers. The register is loaded from the chipset configuration path.

For every page the block drives a hit flag and a translated physical address, both combinational from the memory address. The bus logic around the block uses these to direct the access. The block holds no state machine. It has two kinds of state: a control register and one register per page. All decode logic is combinational from these registers.

Top module: `ems_page_mapper`

## Requirements
- R1: After reset the control byte and all four page registers are zero. The window then starts at 0xC0000, page register 0 reads at I/O 0x0208, and no page hits.
- R2: The window starts at 0xC0000 + (control[3:0] << 14). Page i covers the 16 KB that begins at window start + i*0x4000.
- R3: The I/O base is 0x0208 + (control & 0xF0). Page register i sits at I/O address {i in bits 15:14, base in bits 13:0}.
- R4: An io_wr to a page register address stores io_wdata at the clock edge. An io_rd to that address raises io_claim and returns the stored byte in the same cycle.
- R5: An io_rd that matches no page register leaves io_claim low and drives io_rdata to 0xFF. An io_wr that matches no page register changes no page register.
- R6: A page whose register bit 7 is 0 never hits, and its physical address output is zero.
- R7: For a hit on page i, the physical address is 0xA0000 + (register[6:0] << 14) + mem_addr[13:0]. The output is 22 bits wide.
- R8: A control write takes effect from the clock edge that stores it. The new window and I/O bases apply in the next cycle, and page register contents are kept across a relocation.
- R9: A page whose start would lie at or above 0x100000 never hits any 20-bit address. The start is not wrapped.
- R10: At most one page_hit bit is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Loads the control byte |
| cfg_wdata | input | 8 | Control byte: [3:0] window position, [7:4] I/O position |
| io_addr | input | 16 | I/O address of the current cycle |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, 0xFF when not claimed |
| io_claim | output | 1 | A page register answers the current read |
| mem_addr | input | 20 | CPU memory address |
| page_hit | output | 4 | Per-page hit flag |
| page_phys | output | 88 | Per-page translated address, page i in bits [22*i+21:22*i] |

## Verification
Directed cases come first. They cover:
- Reset values.
- A read at an address one byte off a page register, which separates the exact I/O match from a near miss.
- A relocation that moves both bases. Reading the old and new I/O addresses shows that decoding follows the new byte and that stored page values are kept.
- A disabled page. This separates the enable bit from the page number.
- Window positions that push the top pages past 1 MB. These show whether the page start wraps.

Random control bytes, page values and addresses then cover the rest. Most addresses are aimed inside the current window and some land anywhere. The exact hit vector and the full translated address are compared against a bench model. This exposes errors in page indexing, physical offset and low-bit passthrough.

// File: rtl/ems_pkg.sv
package ems_pkg;
    // 16 KB page granule
    localparam int PAGE_SH = 14;
    localparam int REG_W   = 8;

    typedef struct packed {
        logic              en;
        logic [REG_W-2:0]  num;
    } page_reg_t;
endpackage

// File: rtl/ems_cfg_decode.sv
module ems_cfg_decode #(
    parameter int SEG_W    = 7,
    parameter int IO_OFF_W = 14,
    parameter int WIN_SEG0 = 'h30,
    parameter int IO_BASE0 = 'h208
) (
    input  logic [7:0]          ctl,
    output logic [SEG_W-1:0]    win_seg,
    output logic [IO_OFF_W-1:0] io_base
);
    // Window start expressed in 16 KB segments; may reach past 1 MB.
    always_comb begin
        win_seg = SEG_W'(WIN_SEG0) + SEG_W'(ctl[3:0]);
        io_base = IO_OFF_W'(IO_BASE0) + IO_OFF_W'({ctl[7:4], 4'b0000});
    end
endmodule

// File: rtl/ems_page_slot.sv
module ems_page_slot
    import ems_pkg::*;
#(
    parameter int IDX       = 0,
    parameter int ADDR_W    = 20,
    parameter int PHYS_W    = 22,
    parameter int SEG_W     = ADDR_W - PAGE_SH + 1,
    parameter int PHYS_SEG0 = 'h28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wdata,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [SEG_W-1:0]  win_seg,
    output page_reg_t         q,
    output logic              hit,
    output logic [PHYS_W-1:0] phys
);
    localparam int PSEG_W = PHYS_W - PAGE_SH;

    logic [SEG_W-1:0] my_seg;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr_en) begin
            q <= page_reg_t'(wdata);
        end
    end

    always_comb begin
        my_seg = win_seg + SEG_W'(IDX);
        hit    = q.en && ({1'b0, mem_addr[ADDR_W-1:PAGE_SH]} == my_seg);
        phys   = '0;
        if (hit) begin
            phys = {PSEG_W'(PHYS_SEG0) + PSEG_W'(q.num), mem_addr[PAGE_SH-1:0]};
        end
    end
endmodule

// File: rtl/ems_page_mapper.sv
module ems_page_mapper
    import ems_pkg::*;
#(
    parameter int NPAGE     = 4,
    parameter int ADDR_W    = 20,
    parameter int PHYS_W    = 22,
    parameter int IO_W      = 16,
    parameter int WIN_SEG0  = 'h30,
    parameter int PHYS_SEG0 = 'h28,
    parameter int IO_BASE0  = 'h208
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [7:0]              cfg_wdata,
    input  logic [IO_W-1:0]         io_addr,
    input  logic                    io_wr,
    input  logic                    io_rd,
    input  logic [REG_W-1:0]        io_wdata,
    output logic [REG_W-1:0]        io_rdata,
    output logic                    io_claim,
    input  logic [ADDR_W-1:0]       mem_addr,
    output logic [NPAGE-1:0]        page_hit,
    output logic [NPAGE*PHYS_W-1:0] page_phys
);
    localparam int SEG_W = ADDR_W - PAGE_SH + 1;
    localparam int SEL_W = IO_W - PAGE_SH;

    logic [7:0]         ctl_q;
    logic [SEG_W-1:0]   win_seg;
    logic [PAGE_SH-1:0] io_base;
    logic               io_match;
    logic [NPAGE-1:0]   sel_hit;
    page_reg_t          pr_q [NPAGE];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (cfg_we) begin
            ctl_q <= cfg_wdata;
        end
    end

    ems_cfg_decode #(
        .SEG_W   (SEG_W),
        .IO_OFF_W(PAGE_SH),
        .WIN_SEG0(WIN_SEG0),
        .IO_BASE0(IO_BASE0)
    ) u_dec (
        .ctl    (ctl_q),
        .win_seg(win_seg),
        .io_base(io_base)
    );

    assign io_match = (io_addr[PAGE_SH-1:0] == io_base);

    for (genvar i = 0; i < NPAGE; i++) begin : g_slot
        assign sel_hit[i] = io_match && (io_addr[IO_W-1:PAGE_SH] == SEL_W'(i));

        ems_page_slot #(
            .IDX      (i),
            .ADDR_W   (ADDR_W),
            .PHYS_W   (PHYS_W),
            .SEG_W    (SEG_W),
            .PHYS_SEG0(PHYS_SEG0)
        ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (io_wr && sel_hit[i]),
            .wdata   (io_wdata),
            .mem_addr(mem_addr),
            .win_seg (win_seg),
            .q       (pr_q[i]),
            .hit     (page_hit[i]),
            .phys    (page_phys[i*PHYS_W +: PHYS_W])
        );
    end

    always_comb begin
        io_rdata = '1;
        io_claim = io_rd && (|sel_hit);
        for (int i = 0; i < NPAGE; i++) begin
            if (io_rd && sel_hit[i]) begin
                io_rdata = pr_q[i];
            end
        end
    end
endmodule

// File: rtl/ems_page_mapper_chk.sv
module ems_page_mapper_chk #(
    parameter int NPAGE  = 4,
    parameter int ADDR_W = 20,
    parameter int PHYS_W = 22
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    io_rd,
    input logic                    io_claim,
    input logic [7:0]              io_rdata,
    input logic [ADDR_W-1:0]       mem_addr,
    input logic [NPAGE-1:0]        page_hit,
    input logic [NPAGE*PHYS_W-1:0] page_phys
);
    localparam int LOW_W = 14;

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> page_hit == '0);

    // R10
    single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(page_hit));

    // R5
    float_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !io_claim) |-> io_rdata == 8'hFF);

    // R4
    claim_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_claim |-> io_rd);

    for (genvar i = 0; i < NPAGE; i++) begin : g_pg
        // R6
        idle_phys_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !page_hit[i] |-> page_phys[i*PHYS_W +: PHYS_W] == '0);

        // R7
        low_bits_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            page_hit[i] |-> page_phys[i*PHYS_W +: LOW_W] == mem_addr[LOW_W-1:0]);
    end
endmodule

bind ems_page_mapper ems_page_mapper_chk #(
    .NPAGE (NPAGE),
    .ADDR_W(ADDR_W),
    .PHYS_W(PHYS_W)
) u_chk (.*);

// File: tb/sim_ems_page_mapper.sv
module sim_ems_page_mapper;
    localparam int NP = 4;
    localparam int AW = 20;
    localparam int PW = 22;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_we = 1'b0;
    logic [7:0]      cfg_wdata = '0;
    logic [15:0]     io_addr = '0;
    logic            io_wr = 1'b0;
    logic            io_rd = 1'b0;
    logic [7:0]      io_wdata = '0;
    logic [7:0]      io_rdata;
    logic            io_claim;
    logic [AW-1:0]   mem_addr = '0;
    logic [NP-1:0]   page_hit;
    logic [NP*PW-1:0] page_phys;

    int checks = 0;
    int errors = 0;
    logic [7:0] m_ctl;
    logic [7:0] m_pr [NP];

    always #5 clk = ~clk;

    ems_page_mapper u0 (.*);

    function automatic logic [13:0] m_iobase();
        return 14'h208 + {6'd0, m_ctl[7:4], 4'd0};
    endfunction

    function automatic logic [NP-1:0] exp_hit(input logic [AW-1:0] a);
        logic [NP-1:0] h;
        h = '0;
        for (int i = 0; i < NP; i++) begin
            logic [6:0] seg;
            seg = 7'h30 + {3'd0, m_ctl[3:0]} + 7'(i);
            h[i] = m_pr[i][7] && ({1'b0, a[19:14]} == seg);
        end
        return h;
    endfunction

    function automatic logic [NP*PW-1:0] exp_phys(input logic [AW-1:0] a);
        logic [NP*PW-1:0] p;
        logic [NP-1:0] h;
        p = '0;
        h = exp_hit(a);
        for (int i = 0; i < NP; i++) begin
            if (h[i]) p[i*PW +: PW] = 22'hA0000 + (22'(m_pr[i][6:0]) << 14) + 22'(a[13:0]);
        end
        return p;
    endfunction

    task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        m_ctl = v;
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] v);
        @(negedge clk);
        io_wr = 1'b1; io_addr = a; io_wdata = v;
        @(negedge clk);
        io_wr = 1'b0;
        if (a[13:0] == m_iobase()) m_pr[a[15:14]] = v;
    endtask

    task automatic io_read_chk(input string req, input logic [15:0] a);
        logic       ec;
        logic [7:0] ed;
        ec = (a[13:0] == m_iobase());
        ed = ec ? m_pr[a[15:14]] : 8'hFF;
        @(negedge clk);
        io_rd = 1'b1; io_addr = a;
        #1;
        chk({req, " claim"}, 96'(io_claim), 96'(ec));
        chk({req, " rdata"}, 96'(io_rdata), 96'(ed));
        io_rd = 1'b0;
    endtask

    task automatic mem_chk(input string req, input logic [AW-1:0] a);
        @(negedge clk);
        mem_addr = a;
        #1;
        chk({req, " hit"}, 96'(page_hit), 96'(exp_hit(a)));
        chk({req, " phys"}, 96'(page_phys), 96'(exp_phys(a)));
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        m_ctl = '0;
        for (int i = 0; i < NP; i++) m_pr[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        mem_chk("R1", 20'hC0000);
        io_read_chk("R1", 16'h0208);
        io_read_chk("R1", 16'hC208);

        // R4 R3 store and read back all four registers
        for (int i = 0; i < NP; i++) io_write({2'(i), 14'h208}, 8'h80 | 8'(i * 5 + 1));
        for (int i = 0; i < NP; i++) io_read_chk("R4", {2'(i), 14'h208});

        // R2 R7 translation
        mem_chk("R2", 20'hC8000 + 20'h1234);
        mem_chk("R7", 20'hCFFFF);
        mem_chk("R2 below", 20'hBFFFF);
        mem_chk("R2 above", 20'hD0000);

        // R5 near miss read and unmatched write
        io_read_chk("R5", 16'h0209);
        io_write(16'h0210, 8'hFF);
        for (int i = 0; i < NP; i++) io_read_chk("R5", {2'(i), 14'h208});

        // R6 disabled page
        io_write(16'h4208, 8'h05);
        mem_chk("R6", 20'hC4100);

        // R8 relocation: window 0xCC000, io 0x2D8
        cfg_write(8'hD3);
        io_read_chk("R8 old", 16'h0208);
        io_read_chk("R8 new", 16'h02D8);
        io_read_chk("R8 new", 16'hC2D8);
        mem_chk("R8", 20'hCC000);
        mem_chk("R8", 20'hD8ABC);

        // R3 write via relocated page 3 address
        io_write(16'hC2D8, 8'hFF);
        io_read_chk("R3", 16'hC2D8);

        // R9 pages past 1 MB
        cfg_write(8'h0D);
        for (int i = 0; i < NP; i++) io_write({2'(i), 14'h208}, 8'h80);
        mem_chk("R9", 20'hFC000);
        mem_chk("R9", 20'h00000);
        cfg_write(8'h0F);
        mem_chk("R9", 20'hFFFFF);
        mem_chk("R9", 20'h00123);

        // R10 and all: random mix
        for (int n = 0; n < 400; n++) begin
            int unsigned r;
            r = $urandom % 8;
            if (r == 0) cfg_write(8'($urandom));
            else if (r < 3) io_write({2'($urandom), m_iobase()}, 8'($urandom));
            else if (r == 3) io_read_chk("R4 rnd", {2'($urandom), ($urandom % 2 == 0) ? m_iobase() : 14'($urandom)});
            else if (r == 4) mem_chk("R10 rnd", 20'($urandom));
            else mem_chk("R7 rnd", 20'hC0000 + (20'(m_ctl[3:0]) << 14) + 20'($urandom % 32'h10000));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule